// File: doc/BRIEF.md
# Edge-Interval Serial Byte Receiver

This block recovers bytes from an asynchronous serial line carrying frames of one start bit, eight data bits and one stop bit, with no parity. It never samples at bit centres. It times the gaps between transitions on the line instead. A falling edge on an idle line opens a frame and starts an interval counter. Each later transition captures the elapsed count and restarts the counter. Each captured interval is rounded to the nearest whole number of bit times, and that many bits of the current line level are written into the frame.

The run levels alternate, and the first run is the low start bit. The first data bit lands in bit 0 of the byte. A frame whose tail is a run of ones has no closing transition. A timeout then fires after the bits still owed times the bit width, and it fills those bits with the current level. When the frame is complete, the byte comes out with a one-cycle valid strobe. A framing-error flag comes out with the strobe when the stop bit was low. Start detection is then armed again.

The nominal bit width in clock cycles is a parameter. Intervals that round to zero bits are treated as glitches and discarded.

Top module: `edge_uart_rx`

## Requirements
- R1: After reset, `rx_byte` is 0 and `rx_valid` and `rx_frame_err` are 0.
- R2: A frame starts only on a falling edge of the line while no frame is in progress. A line held high produces no output.
- R3: An interval between accepted edges is converted into round(interval / BIT_CYCLES) bits. Frames whose edges are each displaced by up to 3 cycles (BIT_CYCLES = 16) decode correctly.
- R4: Frame bit 0 is the start bit. Frame bits 1 to 8 are the data bits in time order, and data bit i lands in `rx_byte[i]`, so the least significant bit comes first.
- R5: When no edge arrives for (bits still owed) x BIT_CYCLES cycles, the owed bits take the current line level and the frame completes. A byte ending in ones is delivered without a following edge.
- R6: Frame bit 9 is the stop bit. `rx_frame_err` is 1 when it decoded low and 0 when it decoded high.
- R7: `rx_valid` is a single-cycle pulse per frame, and `rx_frame_err` is never 1 without `rx_valid`.
- R8: An edge whose interval rounds to zero bits is ignored. It neither restarts the interval nor changes the run level, so a short spike near the start of a run leaves the byte unchanged.
- R9: When an edge and the timeout fall in the same cycle, the edge is taken. A falling edge that completes a frame also starts the next one, so frames with exactly one stop bit and no gap are all received.
- R10: After a frame ends with the line low, no new frame starts until the line has returned high and then falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_line | input | 1 | Asynchronous serial input, idles high |
| rx_byte | output | DATA_BITS | Last received byte |
| rx_valid | output | 1 | One-cycle strobe, new byte on `rx_byte` |
| rx_frame_err | output | 1 | Stop bit was low, valid with `rx_valid` |

## Verification
The edge path and the tail-fill timeout can both fire in the same cycle. This happens when the next frame's start edge arrives exactly when the previous frame's stop-bit window runs out. The bench provokes it with back-to-back frames that have one stop bit and no jitter. Two frames are chosen: one whose stop run is one bit long, and one whose last data bits and stop bit form a three-bit run of ones. The coincidence is judged correct when every byte of the burst arrives in order with no framing error, which is only possible if the coinciding falling edge both closed one frame and opened the next.

// File: rtl/eurx_pkg.sv
// Shared types for the edge-interval receiver.
package eurx_pkg;
    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_RUN  = 1'b1
    } rx_state_e;
endpackage

// File: rtl/eurx_edge_detect.sv
// Synchronises the asynchronous serial input and flags its transitions.
// Assumes the line idles high; the chain resets to ones so no edge is
// reported out of reset.
module eurx_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES:0] chain;

    // Shift the line through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[SYNC_STAGES-1:0], line_in};
    end

    assign rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
    assign fall = ~chain[SYNC_STAGES-1] & chain[SYNC_STAGES];
endmodule

// File: rtl/eurx_interval_timer.sv
// Counts cycles since the last accepted transition. A clear wins over
// counting. Assumes the caller clears it before it can wrap.
module eurx_interval_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    output logic [CNT_W-1:0] count
);
    // Restart on clear, advance while a frame is open.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else if (run)   count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/eurx_run_decoder.sv
// Turns one measured interval into a run of equal bits and merges it into
// the frame image. Purely combinational. Assumes pos < FRAME_BITS; bits
// beyond the frame are dropped.
module eurx_run_decoder #(
    parameter int BIT_CYCLES = 16,
    parameter int FRAME_BITS = 10,
    parameter int CNT_W      = 9,
    parameter int POS_W      = 4,
    parameter int N_W        = 5
) (
    input  logic [CNT_W-1:0]      interval,
    input  logic [POS_W-1:0]      pos,
    input  logic                  level,
    input  logic [FRAME_BITS-1:0] frame_in,
    output logic [N_W-1:0]        nbits,
    output logic [FRAME_BITS-1:0] frame_out,
    output logic                  done
);
    localparam int SUM_W = CNT_W + 1;
    localparam int E_W   = N_W + 1;

    logic [SUM_W-1:0] rounded;
    logic [SUM_W-1:0] quotient;
    logic [E_W-1:0]   end_idx;

    // Round to the nearest whole bit count.
    assign rounded  = {1'b0, interval} + SUM_W'(BIT_CYCLES / 2);
    assign quotient = rounded / SUM_W'(BIT_CYCLES);
    assign nbits    = N_W'(quotient);
    assign end_idx  = E_W'(pos) + E_W'(nbits);
    assign done     = (end_idx >= E_W'(FRAME_BITS));

    // Each frame position inside [pos, end_idx) takes the run level.
    for (genvar i = 0; i < FRAME_BITS; i++) begin : g_fill
        assign frame_out[i] = ((E_W'(i) >= E_W'(pos)) && (E_W'(i) < end_idx))
                              ? level : frame_in[i];
    end
endmodule

// File: rtl/edge_uart_rx.sv
// Edge-interval serial byte receiver (start, DATA_BITS data LSB first, stop).
// Measures transition spacing instead of sampling bit centres. Assumes the
// sender's bit width is BIT_CYCLES clocks within half a bit per run.
module edge_uart_rx #(
    parameter int BIT_CYCLES  = 16,
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_line,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_valid,
    output logic                 rx_frame_err
);
    import eurx_pkg::*;

    localparam int FRAME_BITS = DATA_BITS + 2;
    localparam int CNT_W      = $clog2(FRAME_BITS * BIT_CYCLES + 1) + 1;
    localparam int POS_W      = $clog2(FRAME_BITS + 1);
    localparam int N_W        = $clog2(FRAME_BITS + 2) + 1;

    rx_state_e             st;
    logic [POS_W-1:0]      pos;
    logic                  pol;
    logic [FRAME_BITS-1:0] frame_q;
    logic [FRAME_BITS-1:0] frame_nx;
    logic [CNT_W-1:0]      cnt;
    logic [CNT_W-1:0]      interval;
    logic [CNT_W-1:0]      limit;
    logic [N_W-1:0]        nbits;
    logic                  done;
    logic                  rise, fall;
    logic                  accept, tmo, evt, clr;

    eurx_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .line_in(rx_line), .rise(rise), .fall(fall)
    );

    eurx_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(clr), .run(st == RX_RUN), .count(cnt)
    );

    eurx_run_decoder #(
        .BIT_CYCLES(BIT_CYCLES), .FRAME_BITS(FRAME_BITS),
        .CNT_W(CNT_W), .POS_W(POS_W), .N_W(N_W)
    ) u_dec (
        .interval(interval), .pos(pos), .level(pol), .frame_in(frame_q),
        .nbits(nbits), .frame_out(frame_nx), .done(done)
    );

    // Interval includes the edge cycle; timeout limit covers owed bits.
    assign interval = cnt + CNT_W'(1);
    assign limit    = CNT_W'((FRAME_BITS - int'(pos)) * BIT_CYCLES);
    assign accept   = (st == RX_RUN) && (rise || fall) && (nbits != '0);
    assign tmo      = (st == RX_RUN) && !(rise || fall) && (interval >= limit);
    assign evt      = accept || tmo;
    assign clr      = (st == RX_IDLE) || evt;

    // Frame sequencing: start, run merge, completion and re-arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= RX_IDLE;
            pos          <= '0;
            pol          <= 1'b0;
            frame_q      <= '0;
            rx_byte      <= '0;
            rx_valid     <= 1'b0;
            rx_frame_err <= 1'b0;
        end else begin
            rx_valid     <= 1'b0;
            rx_frame_err <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (fall) begin
                        st      <= RX_RUN;
                        pos     <= '0;
                        pol     <= 1'b0;
                        frame_q <= '0;
                    end
                end
                RX_RUN: begin
                    if (evt) begin
                        if (done) begin
                            rx_valid     <= 1'b1;
                            rx_byte      <= frame_nx[DATA_BITS:1];
                            rx_frame_err <= ~frame_nx[FRAME_BITS-1];
                            pos          <= '0;
                            pol          <= 1'b0;
                            frame_q      <= '0;
                            st           <= (accept && fall) ? RX_RUN : RX_IDLE;
                        end else begin
                            pos     <= pos + POS_W'(nbits);
                            pol     <= ~pol;
                            frame_q <= frame_nx;
                        end
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/eurx_checker.sv
// Protocol checks for edge_uart_rx, attached by bind.
module eurx_checker #(
    parameter int FRAME_BITS = 10,
    parameter int BIT_CYCLES = 16,
    parameter int POS_W      = 4,
    parameter int CNT_W      = 9,
    parameter int DATA_BITS  = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rx_valid,
    input logic                  rx_frame_err,
    input logic [DATA_BITS-1:0]  rx_byte,
    input eurx_pkg::rx_state_e   st,
    input logic [POS_W-1:0]      pos,
    input logic [CNT_W-1:0]      cnt
);
    import eurx_pkg::*;

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R7
    err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |-> rx_valid);

    // R2
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_IDLE) |-> (cnt == '0));

    // R5
    timeout_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(FRAME_BITS * BIT_CYCLES));

    // R3
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_RUN) |-> (pos < POS_W'(FRAME_BITS)));

    // R4
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_byte));
endmodule

bind edge_uart_rx eurx_checker #(
    .FRAME_BITS(FRAME_BITS), .BIT_CYCLES(BIT_CYCLES),
    .POS_W(POS_W), .CNT_W(CNT_W), .DATA_BITS(DATA_BITS)
) u_eurx_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
    .rx_byte(rx_byte), .st(st), .pos(pos), .cnt(cnt)
);

// File: tb/edge_uart_rx_bench.sv
// Self-checking bench: directed corner frames plus seeded random frames
// with displaced edges; expected bytes come from the stimulus itself.
module edge_uart_rx_bench;
    localparam int BIT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       rx_frame_err;

    int checks = 0;
    int errors = 0;
    int valids = 0;
    bit finished = 1'b0;
    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    edge_uart_rx #(.BIT_CYCLES(BIT), .DATA_BITS(8)) u_edge_uart_rx (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic lvl, input int cycles);
        rx_line = lvl;
        repeat (cycles) @(negedge clk);
    endtask

    // Expected word: {frame error, byte}
    function automatic logic [8:0] expect_word(input logic [7:0] d, input logic stop);
        return {~stop, d};
    endfunction

    // Drive one frame; internal edges displaced by up to +/-jit cycles.
    task automatic send_frame(input logic [7:0] d, input logic stop,
                              input int jit, input int gap, input string tag);
        logic [9:0] b;
        int i, k, e_cur, e_nx;
        b = {stop, d, 1'b0};
        exp_q.push_back(expect_word(d, stop));
        tag_q.push_back(tag);
        e_cur = 0;
        i = 0;
        while (i < 10) begin
            k = 1;
            while (i + k < 10 && b[i+k] == b[i]) k++;
            e_nx = (i + k < 10 && jit > 0) ? int'($urandom_range(2 * jit, 0)) - jit : 0;
            hold(b[i], k * BIT + e_nx - e_cur);
            e_cur = e_nx;
            i += k;
        end
        if (!stop) hold(1'b0, BIT / 2);
        if (gap > 0) hold(1'b1, gap);
    endtask

    // Compare each delivered byte against the expected queue.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rx_frame_err && !rx_valid)
                check(1'b0, "R7 error flag without valid", 1, 0);
            if (rx_valid) begin
                valids++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected byte", int'(rx_byte), 0);
                end else begin
                    logic [8:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({rx_frame_err, rx_byte} == e, t, int'({rx_frame_err, rx_byte}), int'(e));
                end
            end
        end
    end

    initial begin
        int v0;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rx_byte == 8'h00, "R1 byte after reset", int'(rx_byte), 0);
        check(rx_valid == 1'b0, "R1 valid after reset", int'(rx_valid), 0);
        check(rx_frame_err == 1'b0, "R1 ferr after reset", int'(rx_frame_err), 0);

        // R2 idle high line gives nothing
        v0 = valids;
        hold(1'b1, 300);
        check(valids == v0, "R2 idle line silent", valids - v0, 0);

        // R3/R4 basic patterns
        send_frame(8'h55, 1'b1, 0, 40, "R3 alternating 0x55");
        send_frame(8'h01, 1'b1, 0, 40, "R4 lsb first 0x01");
        send_frame(8'h80, 1'b1, 0, 40, "R4 msb last 0x80");
        send_frame(8'h00, 1'b1, 0, 40, "R3 long low run 0x00");
        // R5 trailing ones need the timeout
        send_frame(8'hFF, 1'b1, 0, 40, "R5 tail fill 0xFF");
        send_frame(8'hF0, 1'b1, 0, 40, "R5 tail fill 0xF0");

        // R6 low stop bit, then R10 line held low
        send_frame(8'hA5, 1'b0, 0, 0, "R6 framing error 0xA5");
        v0 = valids;
        hold(1'b0, 300);
        check(valids == v0, "R10 no frame while line low", valids - v0, 0);
        hold(1'b1, 40);
        send_frame(8'h3E, 1'b1, 0, 40, "R10 recovery frame");
        send_frame(8'h7F, 1'b0, 0, 40, "R6 framing error 0x7F");

        // R8 short spike inside the start bit
        exp_q.push_back(expect_word(8'h0F, 1'b1));
        tag_q.push_back("R8 spike ignored 0x0F");
        hold(1'b0, 3); hold(1'b1, 2); hold(1'b0, BIT - 5);
        hold(1'b1, 4 * BIT); hold(1'b0, 4 * BIT); hold(1'b1, BIT + 40);

        // R9 back-to-back frames: edge coincides with stop timeout
        send_frame(8'h3C, 1'b1, 0, 0, "R9 burst 0x3C");
        send_frame(8'hC3, 1'b1, 0, 0, "R9 burst 0xC3");
        send_frame(8'h5A, 1'b1, 0, 0, "R9 burst 0x5A");
        send_frame(8'hFF, 1'b1, 0, 40, "R9 burst 0xFF");

        // R3/R6 random frames with displaced edges
        for (int n = 0; n < 60; n++) begin
            logic [7:0] d;
            logic st_b;
            int g;
            d    = 8'($urandom());
            st_b = ($urandom_range(7, 0) != 0);
            g    = st_b ? int'($urandom_range(40, 0)) : BIT + int'($urandom_range(20, 0));
            send_frame(d, st_b, 3, g, "R3 random jittered frame");
        end

        hold(1'b1, 20 * BIT);
        // R5 every frame eventually delivered
        check(exp_q.size() == 0, "R5 all frames delivered", exp_q.size(), 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule